// File: doc/BRIEF.md
# Two-Channel External Interrupt Controller

This block watches two active-low external interrupt pins and raises interrupt requests toward a CPU core. Each pin has its own 4-bit field in one shared 8-bit control register. The field holds a trigger-type bit, a pending flag, an enable bit and a priority bit. Software can load the whole register at once, or set or clear a single bit by index. Each request output carries a matching high-priority qualifier.

Each channel runs in one of two modes. In edge mode, a falling edge on the synchronized pin latches the pending flag. The flag stays set until the CPU acknowledges service on that channel's acknowledge input. In level mode nothing is latched: the flag bit shows the synchronized pin level, so the request lasts only as long as the pin is held low. Vector selection and arbitration against other interrupt sources happen outside the block.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, the register reads 0x00 and no request or high-priority output is active while both pins are high.
- R2: Channel c owns register bits 4c+3..4c: bit 4c+3 is priority, bit 4c+2 is enable, bit 4c+1 is the pending flag and bit 4c is the trigger type. A full write takes effect one cycle later and reads back unchanged.
- R3: A single-bit write sets or clears only the bit selected by `bit_sel` (for example, index 2 sets channel 0's enable). All other bits keep their values.
- R4: With type = 1 (edge mode), a high-to-low change of the synchronized pin sets the flag. The flag stays set after the pin returns high. The flag appears three clock edges after the pin falls: two synchronizer stages, then the flag register.
- R5: In edge mode, an acknowledge pulse clears the channel's flag on the next edge.
- R6: With type = 0 (level mode), the flag bit reads 1 exactly while the synchronized pin is low, two edges after the pin changes. A level-mode request never outlasts the low level.
- R7: `irq_req[c]` is high only when channel c's flag and enable bits are both 1. A pending flag with enable 0 raises no request.
- R8: `irq_hi[c]` is high exactly when `irq_req[c]` is high and channel c's priority bit is 1.
- R9: In edge mode, if a detected falling edge coincides with a software clear of the flag or with an acknowledge, the flag ends up set.
- R10: In edge mode, software can set or clear the flag by writing it. In level mode, writes to the flag bit have no effect.
- R11: A pin held low in edge mode produces only one flag event. After the acknowledge, the flag stays clear until a new falling edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xint_n | input | N_CH | Asynchronous active-low interrupt pins |
| reg_wr_en | input | 1 | Full-register write strobe; takes precedence over a bit write |
| reg_wdata | input | 4*N_CH | Full-register write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_sel | input | clog2(4*N_CH) | Index of the bit to write |
| bit_val | input | 1 | Value written to the selected bit |
| reg_rdata | output | 4*N_CH | Current register view (level-mode flags show the pin) |
| svc_ack | input | N_CH | Per-channel service acknowledge pulse |
| irq_req | output | N_CH | Per-channel interrupt request |
| irq_hi | output | N_CH | Per-channel high-priority qualifier |

## Verification
Each result has a fixed latency:
- Register writes and acknowledges show up one rising edge after the strobe.
- A level-mode request follows the pin after two rising edges.
- An edge-mode flag and its request appear after three rising edges.

The bench drives every input on a falling edge and waits an exact number of falling edges before sampling. It checks one edge early that a result has not yet appeared, and on the due edge that it has. The race cases place the software write or the acknowledge precisely in the cycle where the synchronized falling edge is seen.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
  // Field offsets inside one channel's nibble.
  localparam int F_TYPE = 0;
  localparam int F_FLAG = 1;
  localparam int F_EN   = 2;
  localparam int F_PRIO = 3;
  localparam int FIELDS = 4;

  // Pending-flag next state. In level mode the stored bit is kept clear.
  // In edge mode the priority is: hardware set, then acknowledge, then software write.
  function automatic logic next_flag(input logic edge_mode, input logic fall,
                                     input logic ack, input logic sw_wr,
                                     input logic sw_val, input logic cur);
    if (!edge_mode)  return 1'b0;
    else if (fall)   return 1'b1;
    else if (ack)    return 1'b0;
    else if (sw_wr)  return sw_val;
    else             return cur;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
`timescale 1ns/1ps
module xirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
`timescale 1ns/1ps
module xirq_chan
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n,
  input  logic [FIELDS-1:0] wmask,
  input  logic [FIELDS-1:0] wval,
  input  logic              ack,
  output logic [FIELDS-1:0] fields,
  output logic              req,
  output logic              hi,
  output logic              fall_evt,
  output logic              pin_low
);
  logic pin_s, prev_q;
  logic prio_q, en_q, type_q, flag_q;
  logic flag_view;

  xirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
  );

  assign pin_low  = ~pin_s;
  assign fall_evt = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= 1'b0;
      en_q   <= 1'b0;
      type_q <= 1'b0;
      flag_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      if (wmask[F_PRIO]) prio_q <= wval[F_PRIO];
      if (wmask[F_EN])   en_q   <= wval[F_EN];
      if (wmask[F_TYPE]) type_q <= wval[F_TYPE];
      flag_q <= next_flag(type_q, fall_evt, ack, wmask[F_FLAG], wval[F_FLAG], flag_q);
      prev_q <= pin_s;
    end
  end

  assign flag_view = type_q ? flag_q : ~pin_s;

  always_comb begin
    fields         = '0;
    fields[F_TYPE] = type_q;
    fields[F_FLAG] = flag_view;
    fields[F_EN]   = en_q;
    fields[F_PRIO] = prio_q;
  end

  assign req = en_q & flag_view;
  assign hi  = req & prio_q;
endmodule

// File: rtl/xirq_ctrl.sv
`timescale 1ns/1ps
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = N_CH * FIELDS,
  localparam int SEL_W      = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  xint_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             bit_wr_en,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]  svc_ack,
  output logic [N_CH-1:0]  irq_req,
  output logic [N_CH-1:0]  irq_hi
);
  logic [REG_W-1:0] wmask, wval;
  logic [N_CH-1:0]  fall_evt, pin_low;

  // A full write takes precedence over a single-bit write in the same cycle.
  always_comb begin
    wmask = '0;
    wval  = reg_wdata;
    if (reg_wr_en) begin
      wmask = '1;
    end else if (bit_wr_en) begin
      wmask[bit_sel] = 1'b1;
      wval = {REG_W{bit_val}};
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    xirq_chan #(.SYNC_STAGES(SYNC_STAGES)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (xint_n[c]),
      .wmask    (wmask[c*FIELDS +: FIELDS]),
      .wval     (wval[c*FIELDS +: FIELDS]),
      .ack      (svc_ack[c]),
      .fields   (reg_rdata[c*FIELDS +: FIELDS]),
      .req      (irq_req[c]),
      .hi       (irq_hi[c]),
      .fall_evt (fall_evt[c]),
      .pin_low  (pin_low[c])
    );
  end
endmodule

// File: rtl/xirq_ctrl_chk.sv
`timescale 1ns/1ps
module xirq_ctrl_chk
  import xirq_pkg::*;
#(
  parameter int N_CH = 2,
  localparam int REG_W = N_CH * FIELDS,
  localparam int SEL_W = $clog2(REG_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic             bit_wr_en,
  input logic [SEL_W-1:0] bit_sel,
  input logic [REG_W-1:0] reg_rdata,
  input logic [N_CH-1:0]  svc_ack,
  input logic [N_CH-1:0]  irq_req,
  input logic [N_CH-1:0]  irq_hi,
  input logic [N_CH-1:0]  fall_evt,
  input logic [N_CH-1:0]  pin_low
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ck
    localparam int B = c * FIELDS;

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> (reg_rdata[B+F_EN] && reg_rdata[B+F_FLAG])); // R7

    AST_HI_NEEDS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi[c] |-> (irq_req[c] && reg_rdata[B+F_PRIO])); // R8

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B+F_TYPE] && fall_evt[c] && !reg_wr_en && !bit_wr_en)
      |=> reg_rdata[B+F_FLAG]); // R4

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B+F_TYPE] && fall_evt[c] && !reg_wr_en && bit_wr_en &&
       bit_sel != SEL_W'(B+F_TYPE)) |=> reg_rdata[B+F_FLAG]); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B+F_TYPE] && svc_ack[c] && !fall_evt[c] && !reg_wr_en && !bit_wr_en)
      |=> !reg_rdata[B+F_FLAG]); // R5

    AST_LEVEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B+F_TYPE] |-> (reg_rdata[B+F_FLAG] == pin_low[c])); // R6
  end
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.N_CH(N_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .bit_wr_en (bit_wr_en),
  .bit_sel   (bit_sel),
  .reg_rdata (reg_rdata),
  .svc_ack   (svc_ack),
  .irq_req   (irq_req),
  .irq_hi    (irq_hi),
  .fall_evt  (fall_evt),
  .pin_low   (pin_low)
);

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] xint_n = 2'b11;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       bit_wr_en = 1'b0;
  logic [2:0] bit_sel = '0;
  logic       bit_val = 1'b0;
  logic [7:0] reg_rdata;
  logic [1:0] svc_ack = '0;
  logic [1:0] irq_req, irq_hi;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  xirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .xint_n(xint_n),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
    .reg_rdata(reg_rdata), .svc_ack(svc_ack),
    .irq_req(irq_req), .irq_hi(irq_hi)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_wr_en = 1'b1; reg_wdata = v; tick(1); reg_wr_en = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] s, input logic v);
    bit_wr_en = 1'b1; bit_sel = s; bit_val = v; tick(1); bit_wr_en = 1'b0;
  endtask

  task automatic pulse_ack(input logic [1:0] m);
    svc_ack = m; tick(1); svc_ack = '0;
  endtask

  task automatic t_reset();
    chk("R1 reg after reset", reg_rdata, 8'h00);
    chk("R1 req after reset", {6'd0, irq_req}, 8'h00);
    chk("R1 hi after reset", {6'd0, irq_hi}, 8'h00);
  endtask

  task automatic t_layout();
    wr_reg(8'hDD);
    chk("R2 full write readback", reg_rdata, 8'hDD);
    wr_reg(8'h00);
    chk("R2 full clear readback", reg_rdata, 8'h00);
  endtask

  task automatic t_bitwr();
    wr_bit(3'd2, 1'b1);
    chk("R3 set bit 2", reg_rdata, 8'h04);
    wr_bit(3'd6, 1'b1);
    chk("R3 set bit 6", reg_rdata, 8'h44);
    wr_bit(3'd2, 1'b0);
    chk("R3 clear bit 2", reg_rdata, 8'h40);
    wr_reg(8'h00);
  endtask

  task automatic t_edge();
    wr_reg(8'h05);
    xint_n[0] = 1'b0;
    tick(2);
    chk("R4 no req before flag edge", {6'd0, irq_req}, 8'h00);
    tick(1);
    chk("R4 req after edge", {6'd0, irq_req}, 8'h01);
    chk("R4 flag set", reg_rdata, 8'h07);
    xint_n[0] = 1'b1;
    tick(3);
    chk("R4 flag latched after pin high", reg_rdata, 8'h07);
  endtask

  task automatic t_ack();
    pulse_ack(2'b01);
    chk("R5 ack clears flag", reg_rdata, 8'h05);
    chk("R5 ack drops req", {6'd0, irq_req}, 8'h00);
  endtask

  task automatic t_held();
    xint_n[0] = 1'b0;
    tick(3);
    chk("R11 flag on first edge", reg_rdata, 8'h07);
    pulse_ack(2'b01);
    tick(4);
    chk("R11 no refire while held low", reg_rdata, 8'h05);
    xint_n[0] = 1'b1;
    tick(3);
  endtask

  task automatic t_level();
    wr_reg(8'h04);
    xint_n[0] = 1'b0;
    tick(1);
    chk("R6 level not yet through sync", {6'd0, irq_req}, 8'h00);
    tick(1);
    chk("R6 level req", {6'd0, irq_req}, 8'h01);
    chk("R6 level flag mirrors", reg_rdata, 8'h06);
    xint_n[0] = 1'b1;
    tick(2);
    chk("R6 level req drops", {6'd0, irq_req}, 8'h00);
    wr_bit(3'd1, 1'b1);
    chk("R10 level flag write ignored", reg_rdata, 8'h04);
  endtask

  task automatic t_enable();
    wr_reg(8'h01);
    xint_n[0] = 1'b0;
    tick(3);
    chk("R7 flag without enable", reg_rdata, 8'h03);
    chk("R7 no req without enable", {6'd0, irq_req}, 8'h00);
    wr_bit(3'd2, 1'b1);
    chk("R7 req once enabled", {6'd0, irq_req}, 8'h01);
    pulse_ack(2'b01);
    xint_n[0] = 1'b1;
    tick(3);
  endtask

  task automatic t_prio();
    wr_reg(8'h5D);
    xint_n = 2'b00;
    tick(3);
    chk("R8 both flags", reg_rdata, 8'h7F);
    chk("R8 both req", {6'd0, irq_req}, 8'h03);
    chk("R8 hi only ch0", {6'd0, irq_hi}, 8'h01);
    pulse_ack(2'b11);
    chk("R8 hi clears", {6'd0, irq_hi}, 8'h00);
    xint_n = 2'b11;
    tick(3);
  endtask

  task automatic t_swflag();
    wr_reg(8'h05);
    wr_bit(3'd1, 1'b1);
    chk("R10 sw set flag", {6'd0, irq_req}, 8'h01);
    wr_bit(3'd1, 1'b0);
    chk("R10 sw clear flag", {6'd0, irq_req}, 8'h00);
  endtask

  task automatic t_race();
    wr_reg(8'h05);
    xint_n[0] = 1'b0;
    tick(2);
    wr_bit(3'd1, 1'b0);
    chk("R9 hw set beats sw clear", reg_rdata, 8'h07);
    pulse_ack(2'b01);
    xint_n[0] = 1'b1;
    tick(3);
    xint_n[0] = 1'b0;
    tick(2);
    pulse_ack(2'b01);
    chk("R9 hw set beats ack", reg_rdata, 8'h07);
    pulse_ack(2'b01);
    xint_n[0] = 1'b1;
    tick(3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_layout();
    t_bitwr();
    t_edge();
    t_ack();
    t_held();
    t_level();
    t_enable();
    t_prio();
    t_swflag();
    t_race();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule